// File: doc/BRIEF.md
# Translation Unit Control and Fault Registers

This block is the software-visible register file that sits beside a small address-translation core. A host reaches it over a plain single-cycle register bus with 32-bit data. Writes take effect on the clock edge. Read data is combinational from the word address. The block has six groups of state:

- a configuration word: idle mode, auto-idle and a self-clearing soft reset
- a reset-complete flag
- a five-source fault status word with a matching enable mask
- a control word that drives the translation, table-walk and emulator-load enables
- a captured fault address
- a page-table base address aligned to 16 KB

The translation core reports faults as one-cycle pulses, each carrying the device address that caused it. The block keeps those faults until software clears them. It raises one interrupt line for faults that are enabled. It holds the address of the first enabled fault until software has acknowledged it. A soft reset puts every register back to its default. It then keeps the block closed for a fixed number of cycles before it reports completion.

Top module: `mmu_csr_regs`

## Requirements
- R1: Word address 0 reads the revision 0x11: major version in bits 7:4, minor version in bits 3:0, all other bits zero.
- R2: At word address 1 the idle mode is stored in bits 4:3 and auto-idle in bit 0. The codes are 0 force, 1 none, 2 smart. Both fields read back and drive `idle_mode` and `auto_idle`. Bit 2 reads as zero.
- R3: Writing 1 to bit 1 of word 1 starts a soft reset. On the next cycle every register holds its default. Bit 1 of word 1 reads 1 and bit 0 of word 2 reads 0. Bit 0 of word 2 returns to 1 exactly RST_CYCLES clock edges after the write edge, and bit 1 of word 1 clears at the same time. After the power-on reset bit 0 of word 2 reads 1.
- R4: While a soft reset is in progress, bus writes and fault pulses have no effect.
- R5: Word 3 is the fault status: bit 0 TLB miss, bit 1 translation fault, bit 2 emulation miss, bit 3 table-walk fault, bit 4 multi-hit fault. A pulse on `fault_evt[i]` sets bit i whether or not that bit is enabled.
- R6: Writing 1 to a bit of word 3 clears that bit. Writing 0 leaves it unchanged. A fault pulse in the same cycle as a clear of the same bit leaves the bit set.
- R7: Word 4 is the enable mask, with the same bit positions as word 3. `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: Word 5 bits 3:1 drive the enables: bit 1 `xlat_en`, bit 2 `walk_en`, bit 3 `emu_tlb_en`. The other bits read zero.
- R9: Word 6 captures `fault_va` when an enabled fault pulse arrives and no enabled status bit is pending. While an enabled bit stays pending, word 6 does not change.
- R10: Word 7 holds the table base. Bits 13:0 always read zero, and the stored value drives `ttb_base`.
- R11: Word addresses 8 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current word address |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fault_evt | input | NUM_SRC | One-cycle fault pulses, one per source |
| fault_va | input | 32 | Device address that goes with a fault pulse |
| irq | output | 1 | Enabled fault pending |
| xlat_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table-walk enable |
| emu_tlb_en | output | 1 | Emulator TLB-load enable |
| idle_mode | output | 2 | Requested idle mode |
| auto_idle | output | 1 | Auto-idle request |
| ttb_base | output | 32 | Page-table base, low bits zero |

## Verification
The bench builds the block with RST_CYCLES = 5 and keeps the 16-word address space and the 14-bit table alignment. The short reset window lets one run include several complete soft resets, some with faults and writes arriving inside the window, so the blocking and the exact release edge are checked repeatedly. With ADDR_W = 4, half of the address space is unmapped, so random traffic also reaches the read-as-zero and write-ignored decode.

// File: rtl/mmu_csr_pkg.sv
package mmu_csr_pkg;
   localparam int unsigned REG_W = 32;

   // word offsets of the register file
   localparam int unsigned OFF_REV  = 0;
   localparam int unsigned OFF_CFG  = 1;
   localparam int unsigned OFF_STAT = 2;
   localparam int unsigned OFF_FST  = 3;
   localparam int unsigned OFF_FEN  = 4;
   localparam int unsigned OFF_CTRL = 5;
   localparam int unsigned OFF_FVA  = 6;
   localparam int unsigned OFF_TTB  = 7;

   // configuration field positions
   localparam int unsigned CFG_AUTO_BIT = 0;
   localparam int unsigned CFG_SRST_BIT = 1;
   localparam int unsigned CFG_IDLE_LO  = 3;

   typedef enum logic [1:0] {
      IDLE_FORCE = 2'd0,
      IDLE_NONE  = 2'd1,
      IDLE_SMART = 2'd2
   } idle_e;

   // control field: bits 3:1
   typedef struct packed {
      logic emu_load;
      logic walk;
      logic xlat;
   } ctrl_t;
endpackage

// File: rtl/mmu_csr_rstseq.sv
module mmu_csr_rstseq #(
   parameter int unsigned RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(RST_CYCLES);
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/mmu_csr_fault.sv
module mmu_csr_fault #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned VA_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_all,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [VA_W-1:0]    va,
   input  logic [NUM_SRC-1:0] w1c,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] st,
   output logic [NUM_SRC-1:0] en,
   output logic [VA_W-1:0]    fa,
   output logic               irq
);
   logic [NUM_SRC-1:0] st_q;
   logic [NUM_SRC-1:0] en_q;
   logic [VA_W-1:0]    fa_q;
   logic               pend;
   logic               cap;

   assign pend = |(st_q & en_q);
   assign cap  = (|(evt & en_q)) && !pend;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       st_q[i] <= 1'b0;
         else if (clr_all) st_q[i] <= 1'b0;
         else              st_q[i] <= evt[i] | (st_q[i] & ~w1c[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         fa_q <= '0;
      end else if (clr_all) begin
         en_q <= '0;
         fa_q <= '0;
      end else begin
         if (en_we) en_q <= en_wdata;
         if (cap)   fa_q <= va;
      end
   end

   assign st  = st_q;
   assign en  = en_q;
   assign fa  = fa_q;
   assign irq = pend;
endmodule

// File: rtl/mmu_csr_regs.sv
module mmu_csr_regs #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned RST_CYCLES = 8,
   parameter int unsigned TTB_ALIGN  = 14,
   parameter int unsigned REV_MAJOR  = 1,
   parameter int unsigned REV_MINOR  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] fault_evt,
   input  logic [31:0]        fault_va,
   output logic               irq,
   output logic               xlat_en,
   output logic               walk_en,
   output logic               emu_tlb_en,
   output logic [1:0]         idle_mode,
   output logic               auto_idle,
   output logic [31:0]        ttb_base
);
   import mmu_csr_pkg::*;

   localparam int unsigned DW       = REG_W;
   localparam int unsigned TTB_KEEP = DW - TTB_ALIGN;
   localparam logic [7:0]  REV_VAL  = {REV_MAJOR[3:0], REV_MINOR[3:0]};

   if (NUM_SRC != 5) begin : g_bad_src
      $error("NUM_SRC must be 5");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ADDR_W must cover eight words");
   end
   if (TTB_ALIGN <= NUM_SRC || TTB_ALIGN >= DW) begin : g_bad_ttb
      $error("TTB_ALIGN out of range");
   end
   if (RST_CYCLES < 1) begin : g_bad_rc
      $error("RST_CYCLES must be at least 1");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("revision fields are four bits");
   end

   logic                busy;
   logic                done_w;
   logic                sw_start;
   logic                wr_ok;
   logic                sel_cfg, sel_fst, sel_fen, sel_ctrl, sel_ttb;
   logic [1:0]          idle_q;
   logic                auto_q;
   ctrl_t               ctrl_q;
   logic [TTB_KEEP-1:0] ttb_q;
   logic [NUM_SRC-1:0]  st_q;
   logic [NUM_SRC-1:0]  en_q;
   logic [DW-1:0]       fa_q;
   logic [NUM_SRC-1:0]  evt_in;
   logic [NUM_SRC-1:0]  w1c;
   logic                irq_w;
   logic                unused_wbits;

   assign sel_cfg  = bus_addr == ADDR_W'(OFF_CFG);
   assign sel_fst  = bus_addr == ADDR_W'(OFF_FST);
   assign sel_fen  = bus_addr == ADDR_W'(OFF_FEN);
   assign sel_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
   assign sel_ttb  = bus_addr == ADDR_W'(OFF_TTB);

   assign sw_start = bus_wr && !busy && sel_cfg && bus_wdata[CFG_SRST_BIT];
   assign wr_ok    = bus_wr && !busy && !sw_start;
   assign done_w   = !busy;

   mmu_csr_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sw_start),
      .busy  (busy)
   );

   assign evt_in = busy ? '0 : fault_evt;
   assign w1c    = (wr_ok && sel_fst) ? bus_wdata[NUM_SRC-1:0] : '0;

   mmu_csr_fault #(.NUM_SRC(NUM_SRC), .VA_W(DW)) u_fault (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (sw_start),
      .evt      (evt_in),
      .va       (fault_va),
      .w1c      (w1c),
      .en_we    (wr_ok && sel_fen),
      .en_wdata (bus_wdata[NUM_SRC-1:0]),
      .st       (st_q),
      .en       (en_q),
      .fa       (fa_q),
      .irq      (irq_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= IDLE_FORCE;
         auto_q <= 1'b0;
         ctrl_q <= '0;
         ttb_q  <= '0;
      end else if (sw_start) begin
         idle_q <= IDLE_FORCE;
         auto_q <= 1'b0;
         ctrl_q <= '0;
         ttb_q  <= '0;
      end else if (wr_ok) begin
         if (sel_cfg) begin
            idle_q <= bus_wdata[CFG_IDLE_LO +: 2];
            auto_q <= bus_wdata[CFG_AUTO_BIT];
         end
         if (sel_ctrl) ctrl_q <= bus_wdata[3:1];
         if (sel_ttb)  ttb_q  <= bus_wdata[DW-1:TTB_ALIGN];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_REV):  bus_rdata[7:0] = REV_VAL;
         ADDR_W'(OFF_CFG):  begin
            bus_rdata[CFG_IDLE_LO +: 2] = idle_q;
            bus_rdata[CFG_SRST_BIT]     = busy;
            bus_rdata[CFG_AUTO_BIT]     = auto_q;
         end
         ADDR_W'(OFF_STAT): bus_rdata[0] = done_w;
         ADDR_W'(OFF_FST):  bus_rdata[NUM_SRC-1:0] = st_q;
         ADDR_W'(OFF_FEN):  bus_rdata[NUM_SRC-1:0] = en_q;
         ADDR_W'(OFF_CTRL): bus_rdata[3:1] = ctrl_q;
         ADDR_W'(OFF_FVA):  bus_rdata = fa_q;
         ADDR_W'(OFF_TTB):  bus_rdata[DW-1:TTB_ALIGN] = ttb_q;
         default:           bus_rdata = '0;
      endcase
   end

   assign unused_wbits = ^bus_wdata[TTB_ALIGN-1:NUM_SRC];

   assign irq        = irq_w;
   assign xlat_en    = ctrl_q.xlat;
   assign walk_en    = ctrl_q.walk;
   assign emu_tlb_en = ctrl_q.emu_load;
   assign idle_mode  = idle_q;
   assign auto_idle  = auto_q;
   assign ttb_base   = {ttb_q, {TTB_ALIGN{1'b0}}};
endmodule

// File: rtl/mmu_csr_regs_chk.sv
module mmu_csr_regs_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned NUM_SRC = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] fault_evt,
   input logic               irq,
   input logic               xlat_en,
   input logic               walk_en,
   input logic [1:0]         idle_mode,
   input logic [31:0]        ttb_base,
   input logic [NUM_SRC-1:0] st,
   input logic [31:0]        fa,
   input logic               rst_done
);
   logic srst_wr;
   assign srst_wr = bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[1];

   p_srst_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr && rst_done |=> !rst_done && st == '0 && !xlat_en && !walk_en);

   p_release_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_done) |-> idle_mode == 2'd0 && !walk_en && !irq);

   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_done |=> $stable(xlat_en) && $stable(ttb_base) && $stable(st));

   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(3) && rst_done && fault_evt == '0
      |=> (st & $past(bus_wdata[NUM_SRC-1:0])) == '0);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(4) && rst_done && bus_wdata[NUM_SRC-1:0] == '0
      |=> !irq);

   p_fa_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq && rst_done && !srst_wr |=> $stable(fa));
endmodule

bind mmu_csr_regs mmu_csr_regs_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .fault_evt (fault_evt),
   .irq       (irq),
   .xlat_en   (xlat_en),
   .walk_en   (walk_en),
   .idle_mode (idle_mode),
   .ttb_base  (ttb_base),
   .st        (st_q),
   .fa        (fa_q),
   .rst_done  (done_w)
);

// File: tb/mmu_csr_regs_bench.sv
module mmu_csr_regs_bench;
   localparam int AW = 4;
   localparam int NS = 5;
   localparam int RC = 5;
   localparam int TA = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] fault_evt = '0;
   logic [31:0]   fault_va = '0;
   logic          irq, xlat_en, walk_en, emu_tlb_en, auto_idle;
   logic [1:0]    idle_mode;
   logic [31:0]   ttb_base;

   always #5 clk = ~clk;

   mmu_csr_regs #(.ADDR_W(AW), .NUM_SRC(NS), .RST_CYCLES(RC), .TTB_ALIGN(TA)) u_mmu_csr_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_evt(fault_evt),
      .fault_va(fault_va), .irq(irq), .xlat_en(xlat_en), .walk_en(walk_en),
      .emu_tlb_en(emu_tlb_en), .idle_mode(idle_mode), .auto_idle(auto_idle),
      .ttb_base(ttb_base)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   // behavioural reference model
   logic [4:0]  m_st = 0, m_en = 0;
   logic [2:0]  m_ctrl = 0;
   logic [1:0]  m_idle = 0;
   logic        m_auto = 0, m_busy = 0;
   logic [31:0] m_fa = 0, m_ttb = 0;
   int          m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_ctrl = 0; m_idle = 0; m_auto = 0;
         m_busy = 0; m_fa = 0; m_ttb = 0; m_cnt = 0;
      end else if (m_busy) begin
         if (m_cnt == 1) m_busy = 0;
         m_cnt = m_cnt - 1;
      end else if (bus_wr && bus_addr == 1 && bus_wdata[1]) begin
         m_st = 0; m_en = 0; m_ctrl = 0; m_idle = 0; m_auto = 0;
         m_fa = 0; m_ttb = 0; m_busy = 1; m_cnt = RC;
      end else begin
         automatic logic [4:0] en_old = m_en;
         automatic logic       pend   = |(m_st & m_en);
         automatic logic [4:0] clr    = 0;
         if (bus_wr) begin
            case (bus_addr)
               1: begin m_idle = bus_wdata[4:3]; m_auto = bus_wdata[0]; end
               3: clr = bus_wdata[4:0];
               4: m_en = bus_wdata[4:0];
               5: m_ctrl = bus_wdata[3:1];
               7: m_ttb = bus_wdata & 32'hFFFF_C000;
               default: ;
            endcase
         end
         if ((|(fault_evt & en_old)) && !pend) m_fa = fault_va;
         m_st = (m_st & ~clr) | fault_evt;
      end
   end

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return 32'h11;
         1: return {27'd0, m_idle, 1'b0, m_busy, m_auto};
         2: return {31'd0, !m_busy};
         3: return {27'd0, m_st};
         4: return {27'd0, m_en};
         5: return {28'd0, m_ctrl, 1'b0};
         6: return m_fa;
         7: return m_ttb;
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic compare();
      chk(cur_req, bus_rdata, m_read(int'(bus_addr)));
      chk(cur_req, {26'd0, irq, xlat_en, walk_en, emu_tlb_en, idle_mode, auto_idle},
          {26'd0, |(m_st & m_en), m_ctrl[0], m_ctrl[1], m_ctrl[2], m_idle, m_auto});
      chk(cur_req, ttb_base, m_ttb);
   endtask

   task automatic cyc(input logic wr, input int a, input logic [31:0] d,
                      input logic [4:0] e, input logic [31:0] va);
      bus_wr = wr; bus_addr = AW'(a); bus_wdata = d; fault_evt = e; fault_va = va;
      @(negedge clk);
      compare();
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_wr = 0; fault_evt = 0; bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 2, 0, 0, 0);
   endtask

   initial begin
      #2000000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 revision and R3 power-on state
      rd(0, d); chk("R1 revision", d, 32'h11);
      rd(2, d); chk("R3 done after power-on", d, 32'h1);
      rd(1, d); chk("R2 config default", d, 32'h0);

      cur_req = "R2";
      cyc(1, 1, 32'h11, 0, 0);
      chk("R2 idle smart", {30'd0, idle_mode}, 32'd2);
      chk("R2 auto idle", {31'd0, auto_idle}, 32'd1);
      cyc(1, 1, 32'h0C, 0, 0);
      rd(1, d); chk("R2 idle none, bit2 zero", d, 32'h08);

      cur_req = "R8";
      cyc(1, 5, 32'hFFFF_FFFF, 0, 0);
      rd(5, d); chk("R8 control readback", d, 32'hE);
      cyc(1, 5, 32'h4, 0, 0);
      chk("R8 walk only", {29'd0, xlat_en, walk_en, emu_tlb_en}, 32'b010);

      cur_req = "R10";
      cyc(1, 7, 32'hFFFF_FFFF, 0, 0);
      rd(7, d); chk("R10 table base low bits", d, 32'hFFFF_C000);

      cur_req = "R5";
      cyc(1, 4, 32'h1E, 0, 0);
      cyc(0, 0, 0, 5'b00001, 32'hA000_0000);
      rd(3, d); chk("R5 unenabled miss sets status", d, 32'h1);
      chk("R7 unenabled source no irq", {31'd0, irq}, 32'd0);
      rd(6, d); chk("R9 no capture for unenabled", d, 32'h0);

      cur_req = "R9";
      cyc(0, 0, 0, 5'b00010, 32'hB000_0004);
      chk("R7 irq on enabled fault", {31'd0, irq}, 32'd1);
      rd(6, d); chk("R9 first capture", d, 32'hB000_0004);
      cyc(0, 0, 0, 5'b01000, 32'hC000_0008);
      rd(6, d); chk("R9 frozen while pending", d, 32'hB000_0004);

      cur_req = "R6";
      cyc(1, 3, 32'h02, 0, 0);
      rd(3, d); chk("R6 clear one bit", d, 32'h09);
      chk("R7 still pending", {31'd0, irq}, 32'd1);
      cyc(1, 3, 32'h0, 0, 0);
      rd(3, d); chk("R6 write zero keeps", d, 32'h09);
      cyc(1, 3, 32'h10, 5'b10000, 32'hD000_0000);
      rd(3, d); chk("R6 set beats clear", d, 32'h19);
      cyc(1, 3, 32'h1F, 0, 0);
      rd(3, d); chk("R6 clear all", d, 32'h0);
      chk("R7 irq low after clear", {31'd0, irq}, 32'd0);
      cyc(0, 0, 0, 5'b00100, 32'hE000_000C);
      rd(6, d); chk("R9 recapture after clear", d, 32'hE000_000C);

      cur_req = "R7";
      cyc(1, 4, 32'h0, 0, 0);
      chk("R7 masked irq", {31'd0, irq}, 32'd0);
      cyc(1, 4, 32'h04, 0, 0);
      chk("R7 unmasked irq", {31'd0, irq}, 32'd1);

      cur_req = "R11";
      cyc(1, 9, 32'hFFFF_FFFF, 0, 0);
      rd(9, d); chk("R11 unmapped reads zero", d, 32'h0);
      rd(4, d); chk("R11 no side effect", d, 32'h04);

      // soft reset with a fault in the same cycle
      cur_req = "R3";
      cyc(1, 1, 32'h1A, 5'b00100, 32'h1234_0000);
      rd(1, d); chk("R3 srst bit reads one", d, 32'h2);
      rd(2, d); chk("R3 done low", d, 32'h0);
      rd(3, d); chk("R3 status default", d, 32'h0);
      rd(7, d); chk("R3 base default", d, 32'h0);
      cur_req = "R4";
      cyc(1, 5, 32'hE, 5'b11111, 32'h5555_0000);
      cyc(1, 4, 32'h1F, 0, 0);
      idle(RC - 3);
      rd(2, d); chk("R3 done still low before window end", d, 32'h0);
      rd(5, d); chk("R4 control write ignored", d, 32'h0);
      rd(3, d); chk("R4 faults ignored", d, 32'h0);
      idle(1);
      rd(2, d); chk("R3 done exactly after window", d, 32'h1);
      rd(1, d); chk("R3 srst bit self-cleared", d, 32'h0);

      // mixed traffic against the model
      cur_req = "R5";
      for (int k = 0; k < 600; k++) begin
         automatic int          a  = $urandom % 16;
         automatic logic [31:0] w  = $urandom;
         automatic logic        wr = ($urandom % 2) == 0;
         automatic logic [4:0]  e  = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
         if (a == 1 && ($urandom % 10) != 0) w[1] = 1'b0;
         cyc(wr, a, w, e, $urandom);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule